// File: doc/BRIEF.md
# Memory Module Presence and Row Map Decoder

This block walks the serial presence bytes of each memory socket, one byte at a time, through a request/acknowledge read port. For each socket it decides whether a supported synchronous module is fitted. It checks the module's timing bytes, derives the size of each side from the density byte and the bank count, and derives the page size from the column count and data width. From these values it produces the settings the memory controller needs: cumulative row-boundary values in 32 MB units, and one attribute byte per socket that encodes page size and side count.

A pulse on `start_i` clears the results and begins the walk at socket 0. Sockets are handled in ascending order. When all sockets are committed, `done_o` rises with `err_o` at zero. If a module cannot be supported, the walk stops at once. `done_o` then rises with a cause code on `err_o`, and the values committed before the failure stay on the outputs. The byte transfer on the management bus is outside this block: the block only presents a socket number and a byte index, then consumes the byte that comes back.

Top module: `dimm_rowmap`

## Requirements
- R1: A socket is populated only when its memory-type byte (index 2) reads 0x04. Any other value marks the socket empty: no further byte of that socket is read, its attribute byte becomes 0xFF, and it adds zero to the boundaries.
- R2: For a populated socket, bytes are read in the index order 2, 9, 10, 31, 5, 4, 6 (type, cycle time, access time, density, bank count, columns, data width). `rd_req_o` stays high with a stable socket and index until `rd_ack_i` is sampled high, and the byte on `rd_data_i` is taken in that same cycle.
- R3: Side 1 is the highest set bit of the density byte. Bit n gives 4·2^n MB, so bits 3, 4, 5 and 6 give 1, 2, 4 and 8 units of 32 MB. Side 2 equals side 1 only when the density byte has exactly one bit set and the bank count is above 1. In every other case, including a density byte with two different bits set, side 2 is 0.
- R4: The boundary output holds 2·NS+2 bytes, row r at bits [8r+7:8r]. Row 2s is the running total plus side 1 of socket s. Row 2s+1 is row 2s plus side 2. The two extra rows after the last socket carry the final total.
- R5: Page sizes of 2, 4, 8 and 16 KB map to index 0 to 3. The attribute byte is 0xF0 plus the index for a bank count of 1, and 0x00, 0x11, 0x22 or 0x33 for a bank count of 2. Socket s uses `attr_o` bits [8s+7:8s].
- R6: Page size in KB is (data width · 2^columns) / 8192, with the fraction dropped. A width of 72 with 9 columns therefore yields 4 KB.
- R7: Error codes are 1 for a cycle byte other than 0x75, 2 for an access byte other than 0x54, 3 for side 1 below 32 MB (including a zero density byte), 4 for side 1 above 256 MB, 5 for a bank count other than 1 or 2, and 6 for an unsupported page size. When several apply, the lowest code is reported.
- R8: On an error, `done_o` rises with the code and no further read is issued. Rows and attributes of the sockets committed earlier keep their values. Rows, extra rows and attributes not yet committed keep their cleared values (0 and 0xFF).
- R9: After reset, all rows are 0, all attribute bytes are 0xFF, and `done_o`, `err_o` and `rd_req_o` are 0.
- R10: A `start_i` pulse while a walk is in progress is ignored.
- R11: Once `done_o` is high, it and all result outputs hold their values until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new walk (taken when idle or done) |
| rd_req_o | output | 1 | Byte read request |
| rd_sock_o | output | SW | Socket addressed by the read |
| rd_idx_o | output | 8 | Presence byte index addressed by the read |
| rd_ack_i | input | 1 | Read completed, data valid this cycle |
| rd_data_i | input | 8 | Returned presence byte |
| bound_o | output | (2·NS+2)·BW | Cumulative row boundaries, 32 MB units |
| attr_o | output | NS·8 | Per-socket attribute codes |
| done_o | output | 1 | Walk finished (success or error) |
| err_o | output | 3 | Error cause, 0 when none |

## Verification
The hardest situation to reach is a failure in the second socket after the first socket has already been committed. Only that case shows whether partial results are kept while the extra rows stay cleared. The bench drives it from a programmable byte model that answers each request after a fixed latency, with a valid first module and a faulty second one. The same model provides density bytes at both edges of the size window, a truncated page size from an ECC data width, and a second start pulse injected in the middle of a walk.

// File: rtl/dimm_rowmap_pkg.sv
package dimm_rowmap_pkg;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_CYCLE  = 3'd1,
    ERR_ACCESS = 3'd2,
    ERR_SMALL  = 3'd3,
    ERR_LARGE  = 3'd4,
    ERR_BANKS  = 3'd5,
    ERR_PAGE   = 3'd6
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_DONE
  } state_e;

  typedef enum logic [2:0] {
    STP_TYPE,
    STP_CYCLE,
    STP_ACCESS,
    STP_DENS,
    STP_BANKS,
    STP_COLS,
    STP_WIDTH
  } step_e;

endpackage

// File: rtl/rowmap_size_dec.sv
module rowmap_size_dec #(
  parameter int BW      = 8,
  parameter int MIN_BIT = 3,
  parameter int MAX_BIT = 6
) (
  input  logic [7:0]    dens_i,
  input  logic [7:0]    banks_i,
  output logic [BW-1:0] side1_o,
  output logic [BW-1:0] side2_o,
  output logic          small_o,
  output logic          large_o
);

  int   top_bit;
  logic found;
  logic single;

  always_comb begin
    found   = 1'b0;
    top_bit = 0;
    for (int i = 7; i >= 0; i--) begin
      if (!found && dens_i[i]) begin
        found   = 1'b1;
        top_bit = i;
      end
    end
    small_o = !found || (top_bit < MIN_BIT);
    large_o = found && (top_bit > MAX_BIT);
    side1_o = (small_o || large_o) ? '0 : (BW'(1) << (top_bit - MIN_BIT));
    // asymmetric modules collapse to single-sided
    single  = ((dens_i & (dens_i - 8'd1)) == 8'd0);
    side2_o = (banks_i > 8'd1 && single) ? side1_o : '0;
  end

endmodule

// File: rtl/rowmap_attr_enc.sv
module rowmap_attr_enc #(
  parameter int PAGE_SHIFT = 13
) (
  input  logic [7:0] cols_i,
  input  logic [7:0] width_i,
  input  logic [7:0] banks_i,
  output logic [7:0] attr_o,
  output logic       bank_err_o,
  output logic       page_err_o
);

  localparam int PW = 40;

  logic [PW-1:0] bits;
  logic [PW-1:0] kb;
  logic [1:0]    idx;
  logic          hit;

  always_comb begin
    bits = {{(PW-8){1'b0}}, width_i} << cols_i[4:0];
    kb   = bits >> PAGE_SHIFT;
    hit  = 1'b1;
    idx  = 2'd0;
    if      (kb == PW'(2))  idx = 2'd0;
    else if (kb == PW'(4))  idx = 2'd1;
    else if (kb == PW'(8))  idx = 2'd2;
    else if (kb == PW'(16)) idx = 2'd3;
    else                    hit = 1'b0;
    page_err_o = !hit || (cols_i[7:5] != 3'd0);
    bank_err_o = (banks_i != 8'd1) && (banks_i != 8'd2);
    attr_o     = (banks_i == 8'd1) ? {6'b111100, idx} : {2'b00, idx, 2'b00, idx};
  end

endmodule

// File: rtl/rowmap_bound_acc.sv
module rowmap_bound_acc #(
  parameter int NS = 2,
  parameter int BW = 8,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int NB = 2 * NS + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic             last_i,
  input  logic [SW-1:0]    sock_i,
  input  logic [BW-1:0]    side1_i,
  input  logic [BW-1:0]    side2_i,
  output logic [NB*BW-1:0] bound_o
);

  logic [BW-1:0] acc_q;
  logic [BW-1:0] lo_sum, hi_sum;

  assign lo_sum = acc_q + side1_i;
  assign hi_sum = lo_sum + side2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clear_i)  acc_q <= '0;
    else if (commit_i) acc_q <= hi_sum;
  end

  for (genvar r = 0; r < NB; r++) begin : g_row
    logic [BW-1:0] row_q;
    if (r < 2 * NS) begin : g_side
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   row_q <= '0;
        else if (clear_i)                              row_q <= '0;
        else if (commit_i && sock_i == SW'(r / 2))     row_q <= (r % 2 == 0) ? lo_sum : hi_sum;
      end
    end else begin : g_extra
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  row_q <= '0;
        else if (clear_i)             row_q <= '0;
        else if (commit_i && last_i)  row_q <= hi_sum;
      end
    end
    assign bound_o[r*BW +: BW] = row_q;
  end

endmodule

// File: rtl/dimm_rowmap.sv
module dimm_rowmap
  import dimm_rowmap_pkg::*;
#(
  parameter int NS = 2,
  parameter int BW = 8,
  parameter logic [7:0] IDX_TYPE   = 8'd2,
  parameter logic [7:0] IDX_CYCLE  = 8'd9,
  parameter logic [7:0] IDX_ACCESS = 8'd10,
  parameter logic [7:0] IDX_DENS   = 8'd31,
  parameter logic [7:0] IDX_BANKS  = 8'd5,
  parameter logic [7:0] IDX_COLS   = 8'd4,
  parameter logic [7:0] IDX_WIDTH  = 8'd6,
  parameter logic [7:0] TYPE_OK    = 8'h04,
  parameter logic [7:0] CYCLE_OK   = 8'h75,
  parameter logic [7:0] ACCESS_OK  = 8'h54,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int NB = 2 * NS + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             rd_req_o,
  output logic [SW-1:0]    rd_sock_o,
  output logic [7:0]       rd_idx_o,
  input  logic             rd_ack_i,
  input  logic [7:0]       rd_data_i,
  output logic [NB*BW-1:0] bound_o,
  output logic [NS*8-1:0]  attr_o,
  output logic             done_o,
  output logic [2:0]       err_o
);

  state_e        state_q;
  step_e         step_q;
  logic [SW-1:0] sock_q;
  logic          empty_q;
  logic [7:0]    cyc_q, acc_q, dens_q, banks_q, cols_q, width_q;
  logic          done_q;
  err_e          err_q, err_nx;

  logic [BW-1:0] side1, side2;
  logic          too_small, too_large;
  logic [7:0]    attr_code;
  logic          bank_err, page_err;
  logic          clear, commit, last;

  rowmap_size_dec #(.BW(BW)) u_size (
    .dens_i (dens_q),
    .banks_i(banks_q),
    .side1_o(side1),
    .side2_o(side2),
    .small_o(too_small),
    .large_o(too_large)
  );

  rowmap_attr_enc u_attr (
    .cols_i    (cols_q),
    .width_i   (width_q),
    .banks_i   (banks_q),
    .attr_o    (attr_code),
    .bank_err_o(bank_err),
    .page_err_o(page_err)
  );

  always_comb begin
    if      (cyc_q != CYCLE_OK)  err_nx = ERR_CYCLE;
    else if (acc_q != ACCESS_OK) err_nx = ERR_ACCESS;
    else if (too_small)          err_nx = ERR_SMALL;
    else if (too_large)          err_nx = ERR_LARGE;
    else if (bank_err)           err_nx = ERR_BANKS;
    else if (page_err)           err_nx = ERR_PAGE;
    else                         err_nx = ERR_NONE;
  end

  assign clear  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign commit = (state_q == ST_EVAL) && (empty_q || err_nx == ERR_NONE);
  assign last   = (sock_q == SW'(NS - 1));

  rowmap_bound_acc #(.NS(NS), .BW(BW)) u_bound (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .commit_i(commit),
    .last_i  (last),
    .sock_i  (sock_q),
    .side1_i (empty_q ? '0 : side1),
    .side2_i (empty_q ? '0 : side2),
    .bound_o (bound_o)
  );

  always_comb begin
    case (step_q)
      STP_TYPE:   rd_idx_o = IDX_TYPE;
      STP_CYCLE:  rd_idx_o = IDX_CYCLE;
      STP_ACCESS: rd_idx_o = IDX_ACCESS;
      STP_DENS:   rd_idx_o = IDX_DENS;
      STP_BANKS:  rd_idx_o = IDX_BANKS;
      STP_COLS:   rd_idx_o = IDX_COLS;
      default:    rd_idx_o = IDX_WIDTH;
    endcase
  end

  assign rd_req_o  = (state_q == ST_READ);
  assign rd_sock_o = sock_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= STP_TYPE;
      sock_q  <= '0;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
      cyc_q   <= '0;
      acc_q   <= '0;
      dens_q  <= '0;
      banks_q <= '0;
      cols_q  <= '0;
      width_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_READ;
            step_q  <= STP_TYPE;
            sock_q  <= '0;
            empty_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
          end
        end
        ST_READ: begin
          if (rd_ack_i) begin
            case (step_q)
              STP_TYPE:   if (rd_data_i != TYPE_OK) empty_q <= 1'b1;
              STP_CYCLE:  cyc_q   <= rd_data_i;
              STP_ACCESS: acc_q   <= rd_data_i;
              STP_DENS:   dens_q  <= rd_data_i;
              STP_BANKS:  banks_q <= rd_data_i;
              STP_COLS:   cols_q  <= rd_data_i;
              default:    width_q <= rd_data_i;
            endcase
            if (step_q == STP_WIDTH || (step_q == STP_TYPE && rd_data_i != TYPE_OK))
              state_q <= ST_EVAL;
            else
              step_q <= step_e'(step_q + 3'd1);
          end
        end
        ST_EVAL: begin
          if (!empty_q && err_nx != ERR_NONE) begin
            err_q   <= err_nx;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (last) begin
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            sock_q  <= sock_q + SW'(1);
            step_q  <= STP_TYPE;
            empty_q <= 1'b0;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_attr
    logic [7:0] attr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            attr_q <= 8'hFF;
      else if (clear)                         attr_q <= 8'hFF;
      else if (commit && sock_q == SW'(s))    attr_q <= empty_q ? 8'hFF : attr_code;
    end
    assign attr_o[s*8 +: 8] = attr_q;

    // R5
    attr_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o == 3'd0) |->
        (attr_q == 8'hFF || attr_q[7:2] == 6'b111100 ||
         (attr_q[7:6] == 2'b00 && attr_q[3:2] == 2'b00 && attr_q[5:4] == attr_q[1:0])));
  end

  for (genvar r = 0; r < NB - 1; r++) begin : g_mono
    // R4
    bound_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o == 3'd0) |-> (bound_o[(r+1)*BW +: BW] >= bound_o[r*BW +: BW]));
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_idx_o) && $stable(rd_sock_o)));

  // R8
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 3'd0) |-> done_o);

  // R8
  no_req_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);

  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(bound_o) && $stable(attr_o) && $stable(err_o)));

endmodule

// File: tb/dimm_rowmap_tb_top.sv
module dimm_rowmap_tb_top;

  localparam int NS = 2;
  localparam int BW = 8;
  localparam int NB = 2 * NS + 2;

  typedef struct packed {
    logic [NB*8-1:0] bounds;
    logic [NS*8-1:0] attr;
    logic [2:0]      err;
    logic [7:0]      reads;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_req, rd_ack = 1'b0;
  logic [0:0] rd_sock;
  logic [7:0] rd_idx, rd_data = 8'h00;
  logic [NB*BW-1:0] bound;
  logic [NS*8-1:0] attr;
  logic done;
  logic [2:0] err;

  always #2 clk = ~clk;

  dimm_rowmap #(.NS(NS), .BW(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_req_o(rd_req), .rd_sock_o(rd_sock), .rd_idx_o(rd_idx),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .bound_o(bound), .attr_o(attr), .done_o(done), .err_o(err)
  );

  logic [7:0] spd_mem [NS][64];
  int rd_count = 0;
  logic [7:0] rd_log [$];
  int checks = 0;
  int errors = 0;
  exp_t sb_q [$];
  string tag_q [$];

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // byte responder: answers after two idle cycles
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      if (rd_req) begin
        if (wait_cnt == 2) begin
          rd_ack  = 1'b1;
          rd_data = spd_mem[rd_sock][rd_idx[5:0]];
          rd_log.push_back(rd_idx);
          rd_count++;
          wait_cnt = 0;
        end else wait_cnt++;
      end else wait_cnt = 0;
    end
  end

  task automatic set_sock(int s, logic [7:0] typ, logic [7:0] cyc, logic [7:0] acc,
                          logic [7:0] dens, logic [7:0] banks, logic [7:0] cols, logic [7:0] wid);
    for (int i = 0; i < 64; i++) spd_mem[s][i] = 8'h00;
    spd_mem[s][2]  = typ;
    spd_mem[s][9]  = cyc;
    spd_mem[s][10] = acc;
    spd_mem[s][31] = dens;
    spd_mem[s][5]  = banks;
    spd_mem[s][4]  = cols;
    spd_mem[s][6]  = wid;
  endtask

  function automatic exp_t model();
    exp_t e;
    logic [7:0] run;
    bit stop;
    e.bounds = '0;
    e.attr   = '1;
    e.err    = 3'd0;
    e.reads  = 8'd0;
    run  = 8'd0;
    stop = 1'b0;
    for (int s = 0; s < NS; s++) begin
      logic [7:0] s1, s2, at, d, b, c, w;
      logic [63:0] kb;
      int top, code;
      logic [2:0] er;
      if (!stop) begin
        er = 3'd0; s1 = 0; s2 = 0; at = 8'hFF;
        if (spd_mem[s][2] != 8'h04) begin
          e.reads = e.reads + 8'd1;
        end else begin
          e.reads = e.reads + 8'd7;
          d = spd_mem[s][31]; b = spd_mem[s][5]; c = spd_mem[s][4]; w = spd_mem[s][6];
          top = -1;
          for (int i = 0; i < 8; i++) if (d[i]) top = i;
          kb = (c > 8'd31) ? 64'd0 : ((64'(w) << c) / 64'd8192);
          code = (kb == 2) ? 0 : (kb == 4) ? 1 : (kb == 8) ? 2 : (kb == 16) ? 3 : -1;
          if (spd_mem[s][9] != 8'h75)       er = 3'd1;
          else if (spd_mem[s][10] != 8'h54) er = 3'd2;
          else if (top < 3)                 er = 3'd3;
          else if (top > 6)                 er = 3'd4;
          else if (b != 1 && b != 2)        er = 3'd5;
          else if (code < 0)                er = 3'd6;
          if (er == 3'd0) begin
            s1 = 8'(1 << (top - 3));
            s2 = (b > 1 && $countones(d) == 1) ? s1 : 8'd0;
            at = (b == 1) ? (8'hF0 | 8'(code)) : 8'(code * 17);
          end
        end
        if (er != 3'd0) begin
          e.err = er;
          stop  = 1'b1;
        end else begin
          e.bounds[(2*s)*8 +: 8]   = run + s1;
          e.bounds[(2*s+1)*8 +: 8] = run + s1 + s2;
          run = run + s1 + s2;
          e.attr[s*8 +: 8] = at;
          if (s == NS - 1) begin
            e.bounds[(2*NS)*8 +: 8]   = run;
            e.bounds[(2*NS+1)*8 +: 8] = run;
          end
        end
      end
    end
    return e;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // driver: pushes expectation, launches walk, waits for monitor
  task automatic run_case(string tag, bit restart_mid);
    sb_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
    rd_count = 0;
    rd_log.delete();
    pulse_start();
    if (restart_mid) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      string t;
      @(posedge done);
      @(negedge clk);
      if (sb_q.size() != 0) begin
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({t, " bounds"}, 64'(bound), 64'(e.bounds));
        check({t, " attr"},   64'(attr),  64'(e.attr));
        check({t, " err"},    64'(err),   64'(e.err));
        check({t, " reads"},  64'(rd_count), 64'(e.reads));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NB*BW-1:0] b_snap;
    logic [NS*8-1:0]  a_snap;
    int rc_snap;
    for (int s = 0; s < NS; s++) set_sock(s, 8'h00, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 bounds", 64'(bound), 64'd0);
    check("R9 attr", 64'(attr), 64'hFFFF);
    check("R9 done/err/req", {61'd0, done, err != 0, rd_req}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 both empty
    set_sock(0, 8'h02, 8'h75, 8'h54, 8'h10, 2, 9, 64);
    run_case("R1 empty", 1'b0);

    // R3 R4 R5 symmetric double + single, and R2 read order
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h10, 2, 9, 64);
    set_sock(1, 8'h04, 8'h75, 8'h54, 8'h08, 1, 8, 64);
    run_case("R3 R4 R5 mixed", 1'b0);
    check("R2 order", {rd_log[0], rd_log[1], rd_log[2], rd_log[3], rd_log[4], rd_log[5], rd_log[6]},
          {8'd2, 8'd9, 8'd10, 8'd31, 8'd5, 8'd4, 8'd6});

    // R3 asymmetric downgraded, R1 empty second socket
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h30, 2, 10, 64);
    set_sock(1, 8'h00, 8'h75, 8'h54, 8'h10, 2, 9, 64);
    run_case("R3 asym", 1'b0);

    // R1 empty first socket, R4 boundary continues from zero
    set_sock(0, 8'h01, 8'h75, 8'h54, 8'h10, 2, 9, 64);
    set_sock(1, 8'h04, 8'h75, 8'h54, 8'h40, 2, 11, 64);
    run_case("R1 R4 first empty", 1'b0);

    // R6 ECC width truncation, and 16 KB single-sided
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h08, 2, 9, 72);
    set_sock(1, 8'h04, 8'h75, 8'h54, 8'h20, 1, 11, 64);
    run_case("R6 R5 trunc", 1'b0);

    // R7 cycle error, with density also bad (priority)
    set_sock(0, 8'h04, 8'h74, 8'h54, 8'h80, 2, 9, 64);
    run_case("R7 cycle prio", 1'b0);

    // R8 access error in second socket keeps first socket results
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h10, 2, 9, 64);
    set_sock(1, 8'h04, 8'h75, 8'h55, 8'h10, 2, 9, 64);
    run_case("R8 R7 access", 1'b0);

    // R11 outputs held after done
    b_snap = bound; a_snap = attr; rc_snap = rd_count;
    repeat (20) @(negedge clk);
    check("R11 bounds hold", 64'(bound), 64'(b_snap));
    check("R11 attr hold", 64'(attr), 64'(a_snap));
    check("R8 no reads after error", 64'(rd_count), 64'(rc_snap));
    check("R11 done hold", {63'd0, done}, 64'd1);

    // R7 size window edges
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h04, 1, 9, 64);
    run_case("R7 small", 1'b0);
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h00, 1, 9, 64);
    run_case("R7 zero density", 1'b0);
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h80, 1, 9, 64);
    run_case("R7 large", 1'b0);
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h40, 1, 9, 64);
    set_sock(1, 8'h00, 0, 0, 0, 0, 0, 0);
    run_case("R3 max size", 1'b0);

    // R7 bank count and page errors
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h10, 3, 9, 64);
    run_case("R7 banks", 1'b0);
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h10, 2, 7, 64);
    run_case("R7 page", 1'b0);

    // R10 start during walk ignored
    set_sock(0, 8'h04, 8'h75, 8'h54, 8'h20, 2, 10, 64);
    set_sock(1, 8'h04, 8'h75, 8'h54, 8'h10, 1, 9, 64);
    run_case("R10 restart", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule